// File: doc/BRIEF.md
# Two-Voice Phase-Accumulator Tone Synthesizer

This block makes two independent tones by direct digital synthesis and drives a single pulse-width-modulated output with their mix. Each voice keeps a 16-bit phase accumulator and a 16-bit step value. A free-running 8-bit counter defines both the PWM carrier and the audio sample rate. Once per carrier period, each accumulator advances by its step. The upper bits of each phase select an amplitude from an internal waveform ROM, and the two amplitudes are added to form the duty value for the following period.

Voices are controlled by single-cycle commands. A note-on command carries a key number and loads that voice's step from an internal pitch ROM that spans 88 keys. A note-off command silences the voice and rewinds its phase to zero. Parsing the serial message stream that produces these commands happens upstream of this block.

Top module: `dds2_tone_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, both voices clear their step and phase to 0, the duty value becomes 0, the counter becomes 0, and `pwm_out` is low.
- R2: A counter of 256 states counts up by one every cycle and wraps. `pwm_out` is high exactly in the cycles whose count is below the duty value, so every period shows a run of highs followed by lows. A duty value of 0 keeps the output low for the whole period.
- R3: The sample tick is the cycle whose count is 255. Phases advance only on a tick edge, and the duty value changes only on a tick edge. A new duty value therefore applies from count 0 of the next period.
- R4: On each tick, each phase becomes (phase + step) mod 65536.
- R5: A voice's amplitude index is phase bits [15:9]. The amplitude at index i depends only on p = i mod 64. For p = 0..31 it is 0,1,3,5,8,11,15,19,23,28,34,40,45,52,58,64,70,76,83,88,94,100,105,109,113,117,120,123,125,127,128,128. For p = 32..62 it equals the entry at 62 − p. At p = 63 it is 0.
- R6: On a tick, the duty value becomes (amplitude0 + amplitude1) mod 256, where both amplitudes are taken from the phases as they stand after that tick's update. Two peaks of 128 therefore give 0.
- R7: A note-on (`cmd_valid`=1, `cmd_on`=1) with key k in 9..96 sets the step of voice `cmd_voice` from next cycle on, and leaves its phase unchanged. Let n = k − 9, d = 87 − n, o = d div 12 and T = [1860,1971,2088,2212,2344,2483,2631,2787,2953,3128,3314,3511][11 − d mod 12]. The step is T when o = 0, and (T + 2^(o−1)) >> o otherwise. Key 9 gives 23, key 69 gives 738 and key 96 gives 3511.
- R8: A note-off (`cmd_valid`=1, `cmd_on`=0) sets both the step and the phase of voice `cmd_voice` to 0. The key field is ignored.
- R9: A note-on whose key lies outside 9..96 changes nothing. The steps and phases of both voices keep their values.
- R10: A command that arrives in a tick cycle is applied together with that tick. For a note-on, the phase advances with the old step and the new step takes over afterwards. For a note-off, the phase ends at 0, and the duty value written on that tick uses amplitude 0 for that voice.
- R11: A command affects only the voice named by `cmd_voice` (0 or 1). The other voice keeps stepping undisturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_on | input | 1 | 1 = note-on, 0 = note-off |
| cmd_voice | input | 1 | Target voice index |
| cmd_key | input | 7 | Key number used by note-on |
| pwm_out | output | 1 | Pulse-width-modulated mix output |

## Verification
The bench uses the default parameters: two voices, a 16-bit phase, an 8-bit counter and the 88-key pitch range. These keep each sample period at 256 cycles, so every expected duty value can be compared as a count of high cycles per period along with the high-then-low shape. At the top key the phase wraps about every 19 periods, and two voices started together on key 84 both reach the 128 peak on the ninth tick, which exercises the sum wraparound. Commands are placed both mid-period and exactly on the tick cycle, which covers both orderings of a command and a phase update.

// File: rtl/dds2_pkg.sv
package dds2_pkg;

    localparam int NVOICE  = 2;
    localparam int VSEL_W  = (NVOICE > 1) ? $clog2(NVOICE) : 1;
    localparam int ACC_W   = 16;
    localparam int CNT_W   = 8;
    localparam int SMP_W   = 8;
    localparam int IDX_W   = 7;
    localparam int KEY_W   = 7;
    localparam int KEY_LO  = 9;
    localparam int NKEYS   = 88;

    typedef struct packed {
        logic              valid;
        logic              on;
        logic [VSEL_W-1:0] voice;
        logic [KEY_W-1:0]  key;
    } cmd_t;

    // Rising half of one waveform cycle (32 points).
    function automatic logic [7:0] wave_rise(input logic [4:0] p);
        case (p)
            5'd0:  return 8'd0;    5'd1:  return 8'd1;
            5'd2:  return 8'd3;    5'd3:  return 8'd5;
            5'd4:  return 8'd8;    5'd5:  return 8'd11;
            5'd6:  return 8'd15;   5'd7:  return 8'd19;
            5'd8:  return 8'd23;   5'd9:  return 8'd28;
            5'd10: return 8'd34;   5'd11: return 8'd40;
            5'd12: return 8'd45;   5'd13: return 8'd52;
            5'd14: return 8'd58;   5'd15: return 8'd64;
            5'd16: return 8'd70;   5'd17: return 8'd76;
            5'd18: return 8'd83;   5'd19: return 8'd88;
            5'd20: return 8'd94;   5'd21: return 8'd100;
            5'd22: return 8'd105;  5'd23: return 8'd109;
            5'd24: return 8'd113;  5'd25: return 8'd117;
            5'd26: return 8'd120;  5'd27: return 8'd123;
            5'd28: return 8'd125;  5'd29: return 8'd127;
            default: return 8'd128;
        endcase
    endfunction

    // Full 128-entry waveform, folded from the rising half.
    function automatic logic [7:0] wave_amp(input logic [IDX_W-1:0] idx);
        logic [5:0] pos;
        pos = idx[5:0];
        if (!pos[5])
            return wave_rise(pos[4:0]);
        else if (pos == 6'd63)
            return 8'd0;
        else
            return wave_rise(5'(6'd62 - pos));
    endfunction

    // Step values of the highest octave.
    function automatic logic [15:0] top_step(input logic [3:0] j);
        case (j)
            4'd0:  return 16'd1860;  4'd1:  return 16'd1971;
            4'd2:  return 16'd2088;  4'd3:  return 16'd2212;
            4'd4:  return 16'd2344;  4'd5:  return 16'd2483;
            4'd6:  return 16'd2631;  4'd7:  return 16'd2787;
            4'd8:  return 16'd2953;  4'd9:  return 16'd3128;
            4'd10: return 16'd3314;  default: return 16'd3511;
        endcase
    endfunction

    // Step for key offset n (0..87): top-octave value halved per octave with rounding.
    function automatic logic [ACC_W-1:0] key_step(input logic [KEY_W-1:0] n);
        logic [6:0]  d;
        logic [2:0]  oct;
        logic [16:0] v;
        d   = 7'd87 - 7'(n);
        oct = 3'd0;
        for (int i = 0; i < 7; i++) begin
            if (d >= 7'd12) begin
                d   = d - 7'd12;
                oct = oct + 3'd1;
            end
        end
        v = {1'b0, top_step(4'(4'd11 - d[3:0]))};
        if (oct != 3'd0)
            v = (v + (17'd1 << (oct - 3'd1))) >> oct;
        return ACC_W'(v);
    endfunction

endpackage

// File: rtl/dds2_pwm_timer.sv
module dds2_pwm_timer #(
    parameter int CNT_W = dds2_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tick_o,
    output logic             pwm_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign tick_o = &cnt_q;
    assign pwm_o  = (cnt_q < duty_i);
endmodule

// File: rtl/dds2_voice.sv
module dds2_voice #(
    parameter int ACC_W    = dds2_pkg::ACC_W,
    parameter int KEY_W    = dds2_pkg::KEY_W,
    parameter int KEY_LO   = dds2_pkg::KEY_LO,
    parameter int NKEYS    = dds2_pkg::NKEYS,
    parameter int VOICE_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  dds2_pkg::cmd_t   cmd,
    output logic [ACC_W-1:0] phase_o,
    output logic [ACC_W-1:0] step_o,
    output logic [ACC_W-1:0] phase_nxt_o
);
    localparam int KEY_HI = KEY_LO + NKEYS;

    logic [ACC_W-1:0] phase_q, step_q, phase_d, step_d;
    logic             hit, key_ok;

    assign hit    = cmd.valid && (cmd.voice == dds2_pkg::VSEL_W'(VOICE_ID));
    assign key_ok = (cmd.key >= KEY_W'(KEY_LO)) && (cmd.key < KEY_W'(KEY_HI));

    always_comb begin
        phase_d = tick ? (phase_q + step_q) : phase_q;
        step_d  = step_q;
        if (hit) begin
            if (!cmd.on) begin
                phase_d = '0;
                step_d  = '0;
            end else if (key_ok) begin
                step_d = dds2_pkg::key_step(KEY_W'(cmd.key - KEY_W'(KEY_LO)));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            step_q  <= '0;
        end else begin
            phase_q <= phase_d;
            step_q  <= step_d;
        end
    end

    assign phase_o     = phase_q;
    assign step_o      = step_q;
    assign phase_nxt_o = phase_d;
endmodule

// File: rtl/dds2_mixer.sv
module dds2_mixer #(
    parameter int NVOICE = dds2_pkg::NVOICE,
    parameter int ACC_W  = dds2_pkg::ACC_W,
    parameter int IDX_W  = dds2_pkg::IDX_W,
    parameter int SMP_W  = dds2_pkg::SMP_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         tick,
    input  logic [NVOICE-1:0][ACC_W-1:0] phase_nxt_i,
    output logic [SMP_W-1:0]             duty_o
);
    logic [SMP_W-1:0] sum_c, duty_q;

    always_comb begin
        sum_c = '0;
        for (int v = 0; v < NVOICE; v++)
            sum_c = sum_c + SMP_W'(dds2_pkg::wave_amp(phase_nxt_i[v][ACC_W-1 -: IDX_W]));
    end

    always_ff @(posedge clk) begin
        if (rst)       duty_q <= '0;
        else if (tick) duty_q <= sum_c;
    end

    assign duty_o = duty_q;
endmodule

// File: rtl/dds2_tone_gen.sv
module dds2_tone_gen #(
    parameter int NVOICE = dds2_pkg::NVOICE,
    parameter int VSEL_W = dds2_pkg::VSEL_W,
    parameter int KEY_W  = dds2_pkg::KEY_W,
    parameter int ACC_W  = dds2_pkg::ACC_W,
    parameter int CNT_W  = dds2_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_on,
    input  logic [VSEL_W-1:0] cmd_voice,
    input  logic [KEY_W-1:0]  cmd_key,
    output logic              pwm_out
);
    dds2_pkg::cmd_t               cmd;
    logic [CNT_W-1:0]             cnt_w;
    logic [CNT_W-1:0]             duty_w;
    logic                         tick_w;
    logic [NVOICE-1:0][ACC_W-1:0] phase_w, step_w, phase_nxt_w;

    assign cmd.valid = cmd_valid;
    assign cmd.on    = cmd_on;
    assign cmd.voice = cmd_voice;
    assign cmd.key   = cmd_key;

    dds2_pwm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .duty_i (duty_w),
        .cnt_o  (cnt_w),
        .tick_o (tick_w),
        .pwm_o  (pwm_out)
    );

    for (genvar v = 0; v < NVOICE; v++) begin : g_voice
        dds2_voice #(.ACC_W(ACC_W), .KEY_W(KEY_W), .VOICE_ID(v)) u_voice (
            .clk         (clk),
            .rst         (rst),
            .tick        (tick_w),
            .cmd         (cmd),
            .phase_o     (phase_w[v]),
            .step_o      (step_w[v]),
            .phase_nxt_o (phase_nxt_w[v])
        );
    end

    dds2_mixer #(.NVOICE(NVOICE), .ACC_W(ACC_W), .SMP_W(CNT_W)) u_mixer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_w),
        .phase_nxt_i (phase_nxt_w),
        .duty_o      (duty_w)
    );
endmodule

// File: rtl/dds2_tone_gen_chk.sv
module dds2_tone_gen_chk #(
    parameter int NVOICE = dds2_pkg::NVOICE,
    parameter int VSEL_W = dds2_pkg::VSEL_W,
    parameter int KEY_W  = dds2_pkg::KEY_W,
    parameter int ACC_W  = dds2_pkg::ACC_W,
    parameter int CNT_W  = dds2_pkg::CNT_W
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         cmd_valid,
    input logic                         cmd_on,
    input logic [VSEL_W-1:0]            cmd_voice,
    input logic [KEY_W-1:0]             cmd_key,
    input logic                         pwm_out,
    input logic [CNT_W-1:0]             cnt,
    input logic [CNT_W-1:0]             duty,
    input logic [NVOICE-1:0][ACC_W-1:0] phase,
    input logic [NVOICE-1:0][ACC_W-1:0] step
);
    localparam int KEY_LO = dds2_pkg::KEY_LO;
    localparam int KEY_HI = dds2_pkg::KEY_LO + dds2_pkg::NKEYS;

    logic key_bad, last_cnt;
    assign key_bad  = (cmd_key < KEY_W'(KEY_LO)) || (cmd_key >= KEY_W'(KEY_HI));
    assign last_cnt = (cnt == {CNT_W{1'b1}});

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (duty == '0 && cnt == '0 && phase == '0 && step == '0));

    p_low_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !pwm_out);

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_duty_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !last_cnt |=> $stable(duty));

    p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!last_cnt && !cmd_valid) |=> $stable(phase));

    p_step_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(step));

    p_bad_key_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_on && key_bad && !last_cnt) |=> ($stable(step) && $stable(phase)));

    for (genvar v = 0; v < NVOICE; v++) begin : g_v
        p_off_clears_r8: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && !cmd_on && cmd_voice == VSEL_W'(v)) |=> (phase[v] == '0 && step[v] == '0));

        p_other_voice_r11: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && cmd_voice != VSEL_W'(v) && !last_cnt) |=> ($stable(phase[v]) && $stable(step[v])));
    end
endmodule

bind dds2_tone_gen dds2_tone_gen_chk #(
    .NVOICE(NVOICE), .VSEL_W(VSEL_W), .KEY_W(KEY_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_on    (cmd_on),
    .cmd_voice (cmd_voice),
    .cmd_key   (cmd_key),
    .pwm_out   (pwm_out),
    .cnt       (cnt_w),
    .duty      (duty_w),
    .phase     (phase_w),
    .step      (step_w)
);

// File: tb/tb_dds2_tone_gen.sv
module tb_dds2_tone_gen;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_on = 1'b0;
    logic [0:0] cmd_voice = 1'b0;
    logic [6:0] cmd_key = 7'd0;
    logic       pwm_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds2_tone_gen dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_on(cmd_on),
        .cmd_voice(cmd_voice), .cmd_key(cmd_key), .pwm_out(pwm_out)
    );

    typedef struct {
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // Values taken from the requirements (R5, R7).
    int rise[32] = '{0,1,3,5,8,11,15,19,23,28,34,40,45,52,58,64,
                     70,76,83,88,94,100,105,109,113,117,120,123,125,127,128,128};
    int tops[12] = '{1860,1971,2088,2212,2344,2483,2631,2787,2953,3128,3314,3511};

    function automatic int amp_of(int phase);
        int p;
        p = (phase / 512) % 64;
        if (p < 32)  return rise[p];
        if (p == 63) return 0;
        return rise[62 - p];
    endfunction

    function automatic int step_of(int key);
        int n, d, o, t;
        n = key - 9;
        d = 87 - n;
        o = d / 12;
        t = tops[11 - (d % 12)];
        if (o == 0) return t;
        return (t + (1 << (o - 1))) >> o;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model (driver side): pushes the expected duty of each coming period.
    int m_cnt = 0;
    int m_ph[2] = '{0, 0};
    int m_st[2] = '{0, 0};

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_ph  = '{0, 0};
            m_st  = '{0, 0};
            q.delete();
        end else begin
            bit tick;
            int nph[2];
            int nst[2];
            tick = (m_cnt == PER - 1);
            for (int v = 0; v < 2; v++) begin
                nph[v] = tick ? (m_ph[v] + m_st[v]) % 65536 : m_ph[v];
                nst[v] = m_st[v];
                if (cmd_valid && int'(cmd_voice) == v) begin
                    if (!cmd_on) begin
                        nph[v] = 0;
                        nst[v] = 0;
                    end else if (cmd_key >= 7'd9 && cmd_key <= 7'd96) begin
                        nst[v] = step_of(int'(cmd_key));
                    end
                end
            end
            m_ph = nph;
            m_st = nst;
            if (tick) q.push_back('{(amp_of(nph[0]) + amp_of(nph[1])) % 256, cur_tag});
            m_cnt = (m_cnt + 1) % PER;
        end
    end

    // Monitor: measures each full period at the output and pops the scoreboard.
    bit started = 1'b0;
    int hi = 0;
    bit shape_ok = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            started  = 1'b0;
        end else begin
            if (m_cnt == 0) begin
                started  = 1'b1;
                hi       = 0;
                shape_ok = 1'b1;
            end
            if (pwm_out) begin
                if (hi != m_cnt) shape_ok = 1'b0;
                hi++;
            end
            if (started && m_cnt == PER - 1) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R3 empty scoreboard", 0, 1);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    chk(hi == it.exp, it.tag, hi, it.exp);
                    chk(shape_ok, "R2 high-then-low shape", int'(shape_ok), 1);
                end
            end
        end
    end

    task automatic periods(int n);
        repeat (n * PER) @(negedge clk);
    endtask

    task automatic wait_mid();
        do @(negedge clk); while (m_cnt != 20);
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (m_cnt != PER - 1);
    endtask

    task automatic issue(bit on, int v, int key);
        cmd_valid = 1'b1;
        cmd_on    = on;
        cmd_voice = 1'(v);
        cmd_key   = 7'(key);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "R3 watchdog timeout", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pwm_out == 1'b0, "R1 output during reset", int'(pwm_out), 0);
        #1 rst = 1'b0;

        cur_tag = "R1";  periods(3);

        // R7: step loaded, key 69 -> 738
        wait_mid(); cur_tag = "R7"; issue(1, 0, 69); periods(6);
        // R4: top key, phase wraps repeatedly
        wait_mid(); cur_tag = "R4"; issue(1, 0, 96); periods(25);
        // R5: lower key walks the table slowly
        wait_mid(); cur_tag = "R5"; issue(1, 0, 21); periods(20);
        // R11: second voice joins, first keeps stepping
        wait_mid(); cur_tag = "R11"; issue(1, 1, 60); periods(20);
        // R9: out-of-range keys ignored
        wait_mid(); cur_tag = "R9";
        issue(1, 0, 8); issue(1, 1, 97); issue(1, 0, 127); issue(1, 1, 0);
        periods(10);
        // R8: note-off on voice 1
        wait_mid(); cur_tag = "R8"; issue(0, 1, 50); periods(8);
        // R7: lowest key -> 23
        wait_mid(); cur_tag = "R7"; issue(1, 1, 9); periods(8);
        // R10: commands on the tick cycle
        cur_tag = "R10";
        wait_tick(); issue(1, 0, 40); periods(4);
        wait_tick(); issue(0, 1, 0);  periods(4);
        wait_tick(); issue(1, 1, 77); periods(6);
        // R6: both voices in phase on key 84, peaks sum to 256 -> 0
        wait_mid(); cur_tag = "R6";
        issue(0, 0, 0); issue(0, 1, 0); issue(1, 0, 84); issue(1, 1, 84);
        periods(20);
        cur_tag = "R3"; periods(6);
        // R2: both silent -> constant low
        wait_mid(); cur_tag = "R2"; issue(0, 0, 0); issue(0, 1, 0); periods(4);

        finish_run();
    end
endmodule